// File: doc/BRIEF.md
# Synchronizing Debouncing Input Conditioner

This block takes one noisy asynchronous signal, such as a push button or a slide switch, and produces a clean, glitch-free version of it in the system clock domain. The raw signal first crosses into the clock domain through a two-flop synchronizer. A settle counter then watches for disagreement between the synchronized level and the current conditioned output. The output adopts the new level only after the disagreement has lasted for a set number of consecutive clock edges.

The block also emits single-cycle strobes when the conditioned output rises or falls. Downstream logic can use these strobes to act once per press or release without building its own edge detection. Two parameters set the counter width and the wait length. A long wait, such as tens of millions of cycles, turns the block into a human-scale debouncer. A wait of a few cycles filters short electrical spikes.

Top module: `input_conditioner`

## Requirements
- R1: With WAIT_CYCLES = 3, a level change at `noisy` that is first sampled at rising clock edge A, and then held, appears at `conditioned` after edge A+5 and not after edge A+4. In general the change appears WAIT_CYCLES+2 edges after edge A.
- R2: A pulse on `noisy` that is sampled on fewer than WAIT_CYCLES+1 consecutive edges (3 or fewer for the default) leaves `conditioned` unchanged. A pulse sampled on exactly WAIT_CYCLES+1 edges is accepted. The internal settle count never exceeds WAIT_CYCLES.
- R3: The disagreement must be consecutive. Any cycle in which the synchronized level matches `conditioned` restarts the wait from zero.
- R4: `positiveedge` is 1 for exactly one clock cycle: the cycle in which `conditioned` first reads 1 after being 0.
- R5: `negativeedge` is 1 for exactly one clock cycle: the cycle in which `conditioned` first reads 0 after being 1.
- R6: The two strobes are never 1 together. Neither strobe fires while `conditioned` holds its value.
- R7: The active-high `reset` is synchronous. After a clock edge with `reset` = 1, `conditioned`, `positiveedge` and `negativeedge` are all 0. Any synchronizer state and partial count are discarded, so a level held through reset needs the full R1 latency after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| reset | input | 1 | Synchronous active-high reset |
| noisy | input | 1 | Raw asynchronous input |
| conditioned | output | 1 | Debounced, synchronized level |
| positiveedge | output | 1 | One-cycle strobe on a 0-to-1 change of `conditioned` |
| negativeedge | output | 1 | One-cycle strobe on a 1-to-0 change of `conditioned` |

## Verification
The input is driven with isolated pulses 1 to 4 samples wide, in both polarities. These pulses separate rejection from acceptance exactly at the WAIT_CYCLES+1 boundary. Long sustained levels fix the latency to the exact edge and show the timing of each strobe. Two interrupted runs (3 high, 1 low, 3 high) and a steady two-cycle bounce train show whether the count restarts or wrongly accumulates. A reset applied while a count is in progress, with the input still high, shows whether the count and synchronizer state are truly discarded.

// File: rtl/cond_pkg.sv
package cond_pkg;

  // Pair of transition strobes produced alongside the conditioned level.
  typedef struct packed {
    logic rise;
    logic fall;
  } cond_strobe_t;

  // Number of bits needed to hold a value (at least 1).
  function automatic int unsigned bits_for(input longint unsigned value);
    int unsigned n;
    n = 1;
    while ((longint'(1) << n) <= value) n++;
    return n;
  endfunction

endpackage

// File: rtl/cond_sync.sv
// Multi-stage flip-flop synchronizer for a single asynchronous bit.
module cond_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic reset,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (reset) chain_q[0] <= 1'b0;
        else       chain_q[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (reset) chain_q[s] <= 1'b0;
        else       chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/cond_settle.sv
// Settle counter: the output level follows the synchronized level only after
// WAIT_CYCLES+1 consecutive edges of disagreement.
module cond_settle #(
  parameter int unsigned CNT_W       = 2,
  parameter int unsigned WAIT_CYCLES = 3
) (
  input  logic             clk,
  input  logic             reset,
  input  logic             level_in,
  output logic             level_q,
  output logic             commit,
  output logic [CNT_W-1:0] count_q
);

  localparam logic [CNT_W-1:0] WAIT_VAL = CNT_W'(WAIT_CYCLES);

  logic             differs;
  logic             at_limit;
  logic [CNT_W-1:0] count_inc;
  logic [CNT_W-1:0] count_d;

  assign differs   = level_in ^ level_q;
  assign at_limit  = (count_q == WAIT_VAL);
  assign commit    = differs & at_limit;
  assign count_inc = count_q + CNT_W'(1);

  // Clear mux in front of the incrementer.
  always_comb begin
    if (!differs || at_limit) count_d = '0;
    else                      count_d = count_inc;
  end

  always_ff @(posedge clk) begin
    if (reset) begin
      count_q <= '0;
      level_q <= 1'b0;
    end else begin
      count_q <= count_d;
      if (commit) level_q <= level_in;
    end
  end

endmodule

// File: rtl/cond_strobe.sv
// Registered transition strobes, aligned with the cycle the level changes.
module cond_strobe
  import cond_pkg::*;
(
  input  logic         clk,
  input  logic         reset,
  input  logic         commit,
  input  logic         level_q,
  output cond_strobe_t strobe_q
);

  cond_strobe_t strobe_d;

  always_comb begin
    strobe_d.rise = commit & ~level_q;
    strobe_d.fall = commit &  level_q;
  end

  always_ff @(posedge clk) begin
    if (reset) strobe_q <= '0;
    else       strobe_q <= strobe_d;
  end

endmodule

// File: rtl/input_conditioner.sv
module input_conditioner
  import cond_pkg::*;
#(
  parameter int unsigned CNT_W       = 2,
  parameter int unsigned WAIT_CYCLES = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic reset,
  input  logic noisy,
  output logic conditioned,
  output logic positiveedge,
  output logic negativeedge
);

  localparam int unsigned NEED_W = bits_for(WAIT_CYCLES);
  localparam int unsigned USE_W  = (CNT_W > NEED_W) ? CNT_W : NEED_W;

  logic              sync_lvl;
  logic              commit;
  logic [USE_W-1:0]  count;
  cond_strobe_t      strobes;

  cond_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .reset    (reset),
    .async_in (noisy),
    .sync_out (sync_lvl)
  );

  cond_settle #(.CNT_W(USE_W), .WAIT_CYCLES(WAIT_CYCLES)) u_settle (
    .clk      (clk),
    .reset    (reset),
    .level_in (sync_lvl),
    .level_q  (conditioned),
    .commit   (commit),
    .count_q  (count)
  );

  cond_strobe u_strobe (
    .clk      (clk),
    .reset    (reset),
    .commit   (commit),
    .level_q  (conditioned),
    .strobe_q (strobes)
  );

  assign positiveedge = strobes.rise;
  assign negativeedge = strobes.fall;

endmodule

// File: rtl/input_conditioner_chk.sv
module input_conditioner_chk #(
  parameter int unsigned CNT_W       = 2,
  parameter int unsigned WAIT_CYCLES = 3
) (
  input logic             clk,
  input logic             reset,
  input logic             conditioned,
  input logic             positiveedge,
  input logic             negativeedge,
  input logic             sync_lvl,
  input logic [CNT_W-1:0] count
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (reset) past_ok <= 1'b1;
  end

  // R7: reset clears outputs
  a_r7_reset_clears: assert property (@(posedge clk)
    past_ok && $past(reset) |-> !conditioned && !positiveedge && !negativeedge);

  // R2: count bounded by the wait value
  a_r2_count_bound: assert property (@(posedge clk) disable iff (reset || !past_ok)
    count <= CNT_W'(WAIT_CYCLES));

  // R1: a level change needs a full count and a disagreeing sync level
  a_r1_change_needs_count: assert property (@(posedge clk) disable iff (reset || !past_ok)
    !$stable(conditioned) && !$past(reset) |->
      $past(count) == CNT_W'(WAIT_CYCLES) && conditioned == $past(sync_lvl));

  // R3: agreement restarts the wait
  a_r3_agree_clears: assert property (@(posedge clk) disable iff (reset || !past_ok)
    sync_lvl == conditioned |=> count == '0);

  // R4: rise strobe marks the rising cycle only
  a_r4_rise_pulse: assert property (@(posedge clk) disable iff (reset || !past_ok)
    positiveedge |-> conditioned && !$past(conditioned));
  a_r4_rise_single: assert property (@(posedge clk) disable iff (reset || !past_ok)
    positiveedge |=> !positiveedge);

  // R5: fall strobe marks the falling cycle only
  a_r5_fall_pulse: assert property (@(posedge clk) disable iff (reset || !past_ok)
    negativeedge |-> !conditioned && $past(conditioned));

  // R6: exclusive strobes, none while steady
  a_r6_exclusive: assert property (@(posedge clk) disable iff (reset || !past_ok)
    $onehot0({positiveedge, negativeedge}));
  a_r6_quiet_when_steady: assert property (@(posedge clk) disable iff (reset || !past_ok)
    $stable(conditioned) && !$past(reset) |-> !positiveedge && !negativeedge);

endmodule

bind input_conditioner input_conditioner_chk #(
  .CNT_W       (USE_W),
  .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (
  .clk          (clk),
  .reset        (reset),
  .conditioned  (conditioned),
  .positiveedge (positiveedge),
  .negativeedge (negativeedge),
  .sync_lvl     (sync_lvl),
  .count        (count)
);

// File: tb/sim_input_conditioner.sv
`timescale 1ns/1ps
module sim_input_conditioner;

  logic clk = 1'b0;
  logic reset = 1'b1;
  logic noisy = 1'b0;
  logic conditioned, positiveedge, negativeedge;

  always #4 clk = ~clk;  // 125 MHz

  input_conditioner u0 (
    .clk          (clk),
    .reset        (reset),
    .noisy        (noisy),
    .conditioned  (conditioned),
    .positiveedge (positiveedge),
    .negativeedge (negativeedge)
  );

  int checks = 0;
  int fails  = 0;
  int npos, nneg;
  logic done = 1'b0;

  typedef struct packed {
    logic       lvl;
    logic [7:0] width;
    logic       rest;
    logic       exp;
    logic [1:0] epos;
    logic [1:0] eneg;
  } vec_t;

  // pulse level, pulse width (sampled edges), rest level (8 edges), expected
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd1,  1'b0, 1'b0, 2'd0, 2'd0},  // R2 one-sample spike
    '{1'b1, 8'd3,  1'b0, 1'b0, 2'd0, 2'd0},  // R2 longest rejected
    '{1'b1, 8'd4,  1'b0, 1'b0, 2'd1, 2'd1},  // R2 shortest accepted, R4/R5
    '{1'b1, 8'd10, 1'b1, 1'b1, 2'd1, 2'd0},  // R4 sustained high
    '{1'b0, 8'd2,  1'b1, 1'b1, 2'd0, 2'd0},  // R2 low spike rejected
    '{1'b0, 8'd3,  1'b1, 1'b1, 2'd0, 2'd0},  // R2 low boundary rejected
    '{1'b0, 8'd4,  1'b0, 1'b0, 2'd0, 2'd1}   // R5 sustained low
  };

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic check_n(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Advance n rising edges, sampling at each following falling edge.
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (positiveedge) npos++;
      if (negativeedge) nneg++;
      if (positiveedge && negativeedge) begin
        checks++; fails++;
        $display("FAIL R6: both strobes high, actual 11 expected not 11");
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk); @(negedge clk);
    check(conditioned, 1'b0, "R7 reset conditioned");
    check(positiveedge, 1'b0, "R7 reset positiveedge");
    check(negativeedge, 1'b0, "R7 reset negativeedge");
    reset = 1'b0;
    step(8);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      npos = 0; nneg = 0;
      noisy = VECS[v].lvl;
      step(int'(VECS[v].width));
      noisy = VECS[v].rest;
      step(8);
      check(conditioned, VECS[v].exp, $sformatf("R2 vector %0d level", v));
      check_n(npos, int'(VECS[v].epos), $sformatf("R4 vector %0d rise count", v));
      check_n(nneg, int'(VECS[v].eneg), $sformatf("R5 vector %0d fall count", v));
    end

    // R1 latency and R4 strobe timing: drive high, first sampled at edge A
    noisy = 1'b1;
    npos = 0; nneg = 0;
    step(5);
    check(conditioned, 1'b0, "R1 not yet after edge A+4");
    check(positiveedge, 1'b0, "R4 no strobe before change");
    step(1);
    check(conditioned, 1'b1, "R1 changed after edge A+5");
    check(positiveedge, 1'b1, "R4 strobe in change cycle");
    step(1);
    check(positiveedge, 1'b0, "R4 strobe lasts one cycle");
    step(6);
    check_n(npos + nneg, 1, "R6 no strobes while steady");

    // R5 fall timing
    noisy = 1'b0;
    step(5);
    check(negativeedge, 1'b0, "R5 no strobe before change");
    step(1);
    check(conditioned, 1'b0, "R1 fall after edge A+5");
    check(negativeedge, 1'b1, "R5 strobe in change cycle");
    step(1);
    check(negativeedge, 1'b0, "R5 strobe lasts one cycle");
    step(4);

    // R3 interrupted runs: 3 high, 1 low, 3 high
    npos = 0; nneg = 0;
    noisy = 1'b1; step(3);
    noisy = 1'b0; step(1);
    noisy = 1'b1; step(3);
    noisy = 1'b0; step(10);
    check(conditioned, 1'b0, "R3 interrupted run rejected");
    check_n(npos, 0, "R3 no rise strobe");

    // R3 bounce train, two cycles per level
    for (int k = 0; k < 10; k++) begin
      noisy = ~noisy;
      step(2);
    end
    noisy = 1'b0; step(10);
    check(conditioned, 1'b0, "R3 bounce train rejected");
    check_n(npos + nneg, 0, "R6 no strobes during bounce");

    // R7 reset mid-count with the input held high
    noisy = 1'b1; step(4);
    reset = 1'b1; step(1);
    check(conditioned, 1'b0, "R7 reset mid-count");
    reset = 1'b0;
    step(5);
    check(conditioned, 1'b0, "R7 partial count discarded");
    step(1);
    check(conditioned, 1'b1, "R7 full latency after release");

    // R7 reset while high: no fall strobe, output cleared
    reset = 1'b1; step(1);
    check(conditioned, 1'b0, "R7 reset clears high output");
    check(negativeedge, 1'b0, "R7 reset gives no fall strobe");
    reset = 1'b0;
    noisy = 1'b0;
    step(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule